// File: doc/BRIEF.md
# Page ROM wait-state controller

This block paces reads from an external page-mode ROM. Each read is classed as on-page or off-page. A read is on-page when it falls inside the page that the previous completed read opened. The block then holds the bus master off for the number of wait cycles that class calls for. On-page reads use a short wait count held in a 16-bit configuration register. Off-page reads use a wait count that another block supplies.

The same register holds a 4-bit mask over address bits A3 to A6, and this mask sets the page length. A set mask bit takes that address bit out of the page comparison. Software writes the register once after reset and leaves it alone. A mask pattern that does not describe a contiguous page sets a sticky error flag. While that flag is set, every read is treated as off-page.

An access starts with a one-cycle `acc_start` pulse carrying the address and a chip-select region number. The block drives `acc_ready` low for exactly the chosen number of wait cycles and then high for one cycle. `on_page` is high for the whole access when the access was classed as on-page.

Top module: `page_rom_wait`

## Requirements
- R1: After reset `cfg_rdata` reads 0x7000, `mask_err` is 0 and `acc_ready` is 0.
- R2: Bits 15 and 11..4 of `cfg_rdata` always read 0, whatever was written. Bits 14..12 read back the wait count and bits 3..0 read back the mask, both as written.
- R3: On an on-page access, `acc_ready` stays low for exactly W cycles after the start edge and is then high for exactly one cycle, where W is the binary value of register bits 14..12.
- R4: On an off-page access, the wait length is the value of `offpage_waits` sampled at the start edge, with the same low-then-one-cycle-high shape as R3.
- R5: The first access after reset is off-page.
- R6: An access whose `acc_region` differs from the region of the last completed access is off-page.
- R7: Address bits 2..0 never affect the page decision. Any difference in bits 7 and above makes the access off-page.
- R8: Register bit 0 masks A3, bit 1 masks A4, bit 2 masks A5 and bit 3 masks A6. A masked bit may differ and the access is still on-page. An unmasked bit that differs makes the access off-page.
- R9: Writing a mask other than 0000, 0001, 0011, 0111 or 1111 sets `mask_err`. The flag stays set until reset, and while it is set every access is off-page.
- R10: An `acc_start` that arrives while an access is in progress is ignored. No second access follows the ready cycle.
- R11: The stored page address and region are updated when an access completes, so the next access compares against the most recent completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 16 | Write data for the configuration register |
| cfg_rdata | output | 16 | Configuration register read value |
| acc_start | input | 1 | One-cycle pulse that starts a ROM read |
| acc_addr | input | AW (24) | Byte address of the read |
| acc_region | input | RW (2) | Chip-select region of the read |
| offpage_waits | input | OWW (4) | Wait count used for off-page reads |
| acc_ready | output | 1 | High for one cycle when the read may complete |
| on_page | output | 1 | High during an access classed as on-page |
| mask_err | output | 1 | Sticky flag for a prohibited mask pattern |

## Verification
The page decision and the wait count are registered on the edge that samples `acc_start`. `on_page` is therefore valid from the following cycle, and `acc_ready` rises exactly W cycles after that edge. The bench drives and samples on the falling edge. After a start it counts falling edges with `acc_ready` low, then compares that count and `on_page` against its own page model. A register write is visible in `cfg_rdata` and `mask_err` from the next falling edge, and the bench reads it there. One falling edge after each ready cycle, the bench checks that `acc_ready` is low, which confirms that a start sent mid-access left nothing pending.

// File: rtl/page_rom_wait.sv
module page_rom_wait #(
  parameter int AW  = 24,
  parameter int RW  = 2,
  parameter int OWW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [15:0]    cfg_wdata,
  output logic [15:0]    cfg_rdata,
  input  logic           acc_start,
  input  logic [AW-1:0]  acc_addr,
  input  logic [RW-1:0]  acc_region,
  input  logic [OWW-1:0] offpage_waits,
  output logic           acc_ready,
  output logic           on_page,
  output logic           mask_err
);
  localparam int CW = (OWW > 3) ? OWW : 3;

  logic [2:0]    prw;
  logic [3:0]    ma;
  logic          busy, valid, hit_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] last_addr, cur_addr;
  logic [RW-1:0] last_reg, cur_reg;

  wire [AW-1:0] cmp_mask = {{(AW-7){1'b1}}, ~ma, 3'b000};
  wire          hit = valid && (acc_region == last_reg) && !mask_err &&
                      (((acc_addr ^ last_addr) & cmp_mask) == '0);
  wire [3:0]    wmask = cfg_wdata[3:0];
  wire          legal = (wmask & (wmask + 4'd1)) == 4'd0;

  assign cfg_rdata = {1'b0, prw, 8'h00, ma};
  assign acc_ready = busy && (cnt == '0);
  assign on_page   = busy && hit_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prw      <= 3'd7;
      ma       <= 4'd0;
      mask_err <= 1'b0;
    end else if (cfg_wr) begin
      prw <= cfg_wdata[14:12];
      ma  <= wmask;
      if (!legal) mask_err <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      valid     <= 1'b0;
      hit_q     <= 1'b0;
      cnt       <= '0;
      last_addr <= '0;
      cur_addr  <= '0;
      last_reg  <= '0;
      cur_reg   <= '0;
    end else if (!busy) begin
      if (acc_start) begin
        busy     <= 1'b1;
        hit_q    <= hit;
        cnt      <= hit ? CW'(prw) : CW'(offpage_waits);
        cur_addr <= acc_addr;
        cur_reg  <= acc_region;
      end
    end else if (cnt == '0) begin
      busy      <= 1'b0;
      valid     <= 1'b1;
      last_addr <= cur_addr;
      last_reg  <= cur_reg;
    end else begin
      cnt <= cnt - 1'b1;
    end
endmodule

module page_rom_wait_chk #(
  parameter int OWW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic [15:0]    cfg_wdata,
  input logic [15:0]    cfg_rdata,
  input logic           acc_start,
  input logic [OWW-1:0] offpage_waits,
  input logic           acc_ready,
  input logic           on_page,
  input logic           mask_err,
  input logic           busy
);
  logic [7:0] n, prw_c, off_c;
  wire  [3:0] wm = cfg_wdata[3:0];
  wire        bad_mask = !(wm == 4'h0 || wm == 4'h1 || wm == 4'h3 || wm == 4'h7 || wm == 4'hF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n <= '0; prw_c <= '0; off_c <= '0;
    end else if (!busy && acc_start) begin
      n     <= '0;
      prw_c <= 8'(cfg_rdata[14:12]);
      off_c <= 8'(offpage_waits);
    end else if (busy && !acc_ready) begin
      n <= n + 8'd1;
    end

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> !acc_ready);
  p_wait_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> n == (on_page ? prw_c : off_c));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15] == 1'b0 && cfg_rdata[11:4] == 8'h00);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |=> mask_err);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && bad_mask |=> mask_err);
  p_err_offpage_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err && !busy && acc_start |=> !on_page);
endmodule

bind page_rom_wait page_rom_wait_chk #(.OWW(OWW)) u_chk (.*);

// File: tb/page_rom_wait_tb.sv
module page_rom_wait_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic        acc_start = 0;
  logic [23:0] acc_addr = 0;
  logic [1:0]  acc_region = 0;
  logic [3:0]  offpage_waits = 0;
  logic        acc_ready, on_page, mask_err;

  int tests = 0, fails = 0;
  logic [23:0] m_last; logic [1:0] m_reg; bit m_valid = 0;
  logic [2:0] m_prw = 7; logic [3:0] m_ma = 0; bit m_err = 0;

  always #10 clk = ~clk;

  page_rom_wait u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(logic [23:0] a, logic [1:0] r);
    logic [23:0] cm = {17'h1FFFF, ~m_ma, 3'b000};
    return m_valid && r == m_reg && !m_err && (((a ^ m_last) & cm) == 0);
  endfunction

  task automatic wr_cfg(logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    m_prw = d[14:12]; m_ma = d[3:0];
    if (!(d[3:0] inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF})) m_err = 1;
    chk("R2 readback", cfg_rdata, {1'b0, d[14:12], 8'h00, d[3:0]});
    chk("R9 err flag", mask_err, m_err);
  endtask

  task automatic access(string tag, logic [23:0] a, logic [1:0] r, logic [3:0] ow);
    bit hit = model_hit(a, r);
    int exp = hit ? m_prw : ow;
    int n = 0;
    @(negedge clk); acc_start = 1; acc_addr = a; acc_region = r; offpage_waits = ow;
    @(negedge clk); acc_start = 0; acc_addr = ~a; offpage_waits = ~ow;
    chk({tag, " on_page"}, on_page, hit);
    while (!acc_ready && n < 40) begin
      n++;
      if (n == 1) acc_start = 1;
      @(negedge clk);
      acc_start = 0;
    end
    chk({tag, " waits"}, n, exp);
    @(negedge clk);
    chk("R10 no extra access", acc_ready, 0);
    m_last = a; m_reg = r; m_valid = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", cfg_rdata, 16'h7000);
    chk("R1 reset err", mask_err, 0);
    chk("R1 reset ready", acc_ready, 0);
    rst_n = 1;
    access("R5 first", 24'h001230, 0, 4'd9);
    access("R7 low bits", 24'h001237, 0, 4'd9);
    access("R3 on-page", 24'h001231, 0, 4'd2);
    access("R7 A7 differs", 24'h0012B0, 0, 4'd5);
    wr_cfg(16'hFFFF & 16'h300F | 16'h8FF0);
    wr_cfg(16'h2001);
    access("R4 off", 24'h002000, 1, 4'd3);
    access("R8 A3 masked", 24'h002008, 1, 4'd3);
    access("R8 A4 unmasked", 24'h002018, 1, 4'd6);
    wr_cfg(16'h000F);
    access("R8 A6 masked", 24'h002058, 1, 4'd6);
    access("R3 zero waits", 24'h002000, 1, 4'd6);
    access("R6 region change", 24'h002000, 2, 4'd4);
    access("R11 page A", 24'h004000, 2, 4'd1);
    access("R11 page B", 24'h005000, 2, 4'd1);
    access("R11 back to A", 24'h004000, 2, 4'd1);
    for (int i = 0; i < 150; i++) begin
      logic [23:0] base;
      if ($urandom % 20 == 0) begin
        logic [3:0] mk;
        case ($urandom % 5) 0: mk = 0; 1: mk = 1; 2: mk = 3; 3: mk = 7; default: mk = 15; endcase
        wr_cfg({1'b0, 3'($urandom), 8'h00, mk});
      end
      case ($urandom % 3) 0: base = 24'h001000; 1: base = 24'h001080; default: base = 24'h003000; endcase
      access("R3 R4 random", base + 24'($urandom % 128),
             ($urandom % 4 == 0) ? 2'($urandom) : m_reg, 4'($urandom));
    end
    wr_cfg(16'h5005);
    access("R9 same page", m_last, m_reg, 4'd2);
    wr_cfg(16'h5003);
    access("R9 sticky off", m_last, m_reg, 4'd3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule